// File: doc/BRIEF.md
# Ballast supply mode sequencer

This block steps the supply of a lamp ballast controller through four modes: start-up, save, operating and shut-down. Threshold comparators on the chip supply and on the microcontroller reference reach it as single-bit flags. The low-side and high-side half-bridge command inputs also arrive here. From these the block picks the active mode and drives the enables that the analog parts need in that mode. Those enables cover the high-voltage start-up generator, the reference output and its current capability, the reference sink clamp, the supply regulator, overcurrent protection and the gate drivers.

The flags and commands are asynchronous to the block clock, so each one goes through a two-flop synchroniser before any logic uses it. Two timers are plain cycle counters sized by parameters. The first sets the minimum time spent in save mode before operating mode may start. The second sets how long the low-side command may stay quiet before operating mode falls back to save.

Top module: `ballast_mode_seq`

## Requirements
- R1: Reset puts the block in start-up mode. The mode code on `mode` is 0 for start-up, 1 for save, 2 for operating and 3 for shut-down.
- R2: Every input passes two synchroniser flops and then the mode register. A change driven just after one rising edge therefore shows on `mode` after the third rising edge that follows. From start-up the block moves to save when `vcc_above_on` is 1.
- R3: In save mode `gen_on` turns off while `vcc_above_on` is 1 and turns on while `vcc_below_save` is 1. When neither flag is set it keeps its last value.
- R4: Save goes to operating on a falling edge of the synchronised `hs_cmd` only if the block has been in save for at least `DWELL_CYC` clock cycles at the cycle the edge is seen. An earlier edge is ignored.
- R5: The save-to-operating move also needs `ref_good` to be 1. A falling `hs_cmd` edge while `ref_good` is 0 leaves the block in save.
- R6: Operating returns to save after `IDLE_CYC` consecutive cycles with no edge on the synchronised `ls_cmd`. Every edge of `ls_cmd`, and entry into operating, restarts that count.
- R7: Operating goes to shut-down when `vcc_below_off` or `ref_low` is 1. This takes priority over the inactivity return, and shut-down ignores the inactivity timer.
- R8: Shut-down moves to save when `vcc_above_on` is 1. Save and shut-down both move to start-up when `vcc_below_refoff` is 1, and this takes priority over every other move.
- R9: The enables depend on the mode. In start-up only `gen_on` and `ref_clamp` are 1. In save only `ref_en` is set, together with `gen_on` as given by R3. In shut-down `gen_on` and `ref_en` are 1. In operating `ref_en`, `ref_hi_cur`, `reg_en`, `ocp_en` and `drv_en` are 1 and `gen_on` is 0. `reg_en`, `ocp_en` and `drv_en` are 0 in every mode except operating.
- R10: A flag that has no exit in the current mode does not change the mode. A falling `hs_cmd` in start-up and a set `vcc_below_off` in save are two examples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vcc_above_on | input | 1 | Supply is above the turn-on level |
| vcc_below_save | input | 1 | Supply is below the save-mode level |
| vcc_below_off | input | 1 | Supply is below the turn-off level |
| vcc_below_refoff | input | 1 | Supply is below the reference-off level |
| ref_good | input | 1 | Reference is above its healthy level |
| ref_low | input | 1 | Reference is below its fault level |
| ls_cmd | input | 1 | Low-side half-bridge command |
| hs_cmd | input | 1 | High-side half-bridge command |
| mode | output | 2 | Current mode code |
| gen_on | output | 1 | High-voltage start-up generator enable |
| ref_en | output | 1 | Reference output enable |
| ref_hi_cur | output | 1 | Reference high-current capability |
| ref_clamp | output | 1 | Reference sink clamp enable |
| reg_en | output | 1 | Supply regulator enable |
| ocp_en | output | 1 | Overcurrent protection enable |
| drv_en | output | 1 | Gate driver enable |

## Verification
The bench places a high-side falling edge so that it is seen one cycle before the dwell count reaches its limit, and again exactly at the limit. A design that compares with an off-by-one bound then enters operating mode too early or rejects the legal edge. It runs the inactivity window with and without low-side edges and samples one cycle on each side of the expected return to save. A timer that does not restart on an edge, or that uses a strict bound, returns on the wrong cycle. It also raises the reference-off flag and the turn-on flag together in shut-down, and it holds shut-down past the idle window. This catches a wrong priority order, or an inactivity timer that still acts outside operating mode.

// File: rtl/bms_pkg.sv
package bms_pkg;

  typedef enum logic [1:0] {
    MODE_START = 2'd0,
    MODE_SAVE  = 2'd1,
    MODE_RUN   = 2'd2,
    MODE_HALT  = 2'd3
  } mode_e;

  // bit positions inside the synchronised flag vector
  localparam int unsigned FLAG_ABOVE_ON   = 0;
  localparam int unsigned FLAG_BELOW_SAVE = 1;
  localparam int unsigned FLAG_BELOW_OFF  = 2;
  localparam int unsigned FLAG_BELOW_REF  = 3;
  localparam int unsigned FLAG_REF_GOOD   = 4;
  localparam int unsigned FLAG_REF_LOW    = 5;
  localparam int unsigned FLAG_LS         = 6;
  localparam int unsigned FLAG_HS         = 7;
  localparam int unsigned FLAG_COUNT      = 8;

  typedef struct packed {
    logic gen_on;
    logic ref_en;
    logic ref_hi_cur;
    logic ref_clamp;
    logic reg_en;
    logic ocp_en;
    logic drv_en;
  } mode_out_t;

  // saturating increment toward a limit
  function automatic int unsigned sat_inc(int unsigned cnt, int unsigned lim);
    return (cnt < lim) ? cnt + 1 : lim;
  endfunction

  function automatic logic reached(int unsigned cnt, int unsigned lim);
    return cnt >= lim;
  endfunction

  function automatic mode_out_t decode_mode(mode_e m, logic save_gen);
    mode_out_t o;
    o = '0;
    unique case (m)
      MODE_START: begin
        o.gen_on    = 1'b1;
        o.ref_clamp = 1'b1;
      end
      MODE_SAVE: begin
        o.gen_on = save_gen;
        o.ref_en = 1'b1;
      end
      MODE_RUN: begin
        o.ref_en     = 1'b1;
        o.ref_hi_cur = 1'b1;
        o.reg_en     = 1'b1;
        o.ocp_en     = 1'b1;
        o.drv_en     = 1'b1;
      end
      MODE_HALT: begin
        o.gen_on = 1'b1;
        o.ref_en = 1'b1;
      end
      default: o = '0;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/bms_sync.sv
module bms_sync #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1_q[g] <= 1'b0;
        stage2_q[g] <= 1'b0;
      end else begin
        stage1_q[g] <= async_i[g];
        stage2_q[g] <= stage1_q[g];
      end
    end
  end

  assign sync_o = stage2_q;
endmodule

// File: rtl/bms_timers.sv
module bms_timers
  import bms_pkg::*;
#(
  parameter int unsigned DWELL_CYC = 1000,
  parameter int unsigned IDLE_CYC  = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_chg,
  input  logic ls_s,
  output logic dwell_done,
  output logic idle_expired
);
  localparam int unsigned DW = $clog2(DWELL_CYC + 1);
  localparam int unsigned IW = $clog2(IDLE_CYC + 1);

  logic          ls_d_q;
  logic          ls_edge;
  logic [DW-1:0] dwell_q;
  logic [IW-1:0] idle_q;

  assign ls_edge = ls_s ^ ls_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ls_d_q  <= 1'b0;
      dwell_q <= '0;
      idle_q  <= '0;
    end else begin
      ls_d_q <= ls_s;
      if (mode_chg) dwell_q <= '0;
      else          dwell_q <= DW'(sat_inc(32'(dwell_q), DWELL_CYC));
      if (mode_chg || ls_edge) idle_q <= '0;
      else                     idle_q <= IW'(sat_inc(32'(idle_q), IDLE_CYC));
    end
  end

  assign dwell_done   = reached(32'(dwell_q), DWELL_CYC);
  assign idle_expired = (32'(idle_q) == IDLE_CYC);

  a_r4_dwell_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(dwell_q) <= DWELL_CYC);
  a_r6_idle_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(idle_q) <= IDLE_CYC);
  a_r6_edge_restart: assert property (@(posedge clk) disable iff (!rst_n)
    ls_edge |=> !idle_expired);
endmodule

// File: rtl/bms_fsm.sv
module bms_fsm
  import bms_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  f_above_on,
  input  logic  f_below_off,
  input  logic  f_below_ref,
  input  logic  f_ref_good,
  input  logic  f_ref_low,
  input  logic  hs_s,
  input  logic  dwell_done,
  input  logic  idle_expired,
  output mode_e mode_q,
  output logic  mode_chg
);
  mode_e mode_d;
  logic  hs_d_q;
  logic  hs_fall;

  assign hs_fall = hs_d_q & ~hs_s;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_START: if (f_above_on) mode_d = MODE_SAVE;
      MODE_SAVE: begin
        if (f_below_ref)                                mode_d = MODE_START;
        else if (dwell_done && f_ref_good && hs_fall)   mode_d = MODE_RUN;
      end
      MODE_RUN: begin
        if (f_below_off || f_ref_low) mode_d = MODE_HALT;
        else if (idle_expired)        mode_d = MODE_SAVE;
      end
      MODE_HALT: begin
        if (f_below_ref)     mode_d = MODE_START;
        else if (f_above_on) mode_d = MODE_SAVE;
      end
      default: mode_d = MODE_START;
    endcase
  end

  assign mode_chg = (mode_d != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_START;
      hs_d_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      hs_d_q <= hs_s;
    end
  end

  a_r2_start_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_START) |=> (mode_q == MODE_START || mode_q == MODE_SAVE));
  a_r4_dwell_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_RUN && $past(mode_q) == MODE_SAVE) |-> $past(dwell_done));
  a_r7_fault_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_RUN && (f_below_off || f_ref_low)) |=> (mode_q == MODE_HALT));
  a_r6_idle_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_RUN && idle_expired && !f_below_off && !f_ref_low) |=> (mode_q == MODE_SAVE));
  a_r8_refoff: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_SAVE || mode_q == MODE_HALT) && f_below_ref) |=> (mode_q == MODE_START));
endmodule

// File: rtl/bms_outdec.sv
module bms_outdec
  import bms_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  mode_e     mode_q,
  input  logic      f_above_on,
  input  logic      f_below_save,
  output mode_out_t outs
);
  logic save_gen_q;

  // hysteresis for the generator while in save mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            save_gen_q <= 1'b1;
    else if (f_above_on)   save_gen_q <= 1'b0;
    else if (f_below_save) save_gen_q <= 1'b1;
  end

  assign outs = decode_mode(mode_q, save_gen_q);

  a_r9_run_only: assert property (@(posedge clk) disable iff (!rst_n)
    (outs.drv_en || outs.reg_en || outs.ocp_en) |-> (mode_q == MODE_RUN));
  a_r9_clamp_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(outs.ref_clamp && outs.ref_en));
  a_r3_gen_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SAVE && f_above_on) |=> (mode_q != MODE_SAVE || !outs.gen_on));
endmodule

// File: rtl/ballast_mode_seq.sv
module ballast_mode_seq
  import bms_pkg::*;
#(
  parameter int unsigned DWELL_CYC = 1000,
  parameter int unsigned IDLE_CYC  = 10000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vcc_above_on,
  input  logic       vcc_below_save,
  input  logic       vcc_below_off,
  input  logic       vcc_below_refoff,
  input  logic       ref_good,
  input  logic       ref_low,
  input  logic       ls_cmd,
  input  logic       hs_cmd,
  output logic [1:0] mode,
  output logic       gen_on,
  output logic       ref_en,
  output logic       ref_hi_cur,
  output logic       ref_clamp,
  output logic       reg_en,
  output logic       ocp_en,
  output logic       drv_en
);
  logic [FLAG_COUNT-1:0] raw_flags;
  logic [FLAG_COUNT-1:0] sflags;
  logic                  dwell_done;
  logic                  idle_expired;
  logic                  mode_chg;
  mode_e                 mode_q;
  mode_out_t             outs;

  always_comb begin
    raw_flags                  = '0;
    raw_flags[FLAG_ABOVE_ON]   = vcc_above_on;
    raw_flags[FLAG_BELOW_SAVE] = vcc_below_save;
    raw_flags[FLAG_BELOW_OFF]  = vcc_below_off;
    raw_flags[FLAG_BELOW_REF]  = vcc_below_refoff;
    raw_flags[FLAG_REF_GOOD]   = ref_good;
    raw_flags[FLAG_REF_LOW]    = ref_low;
    raw_flags[FLAG_LS]         = ls_cmd;
    raw_flags[FLAG_HS]         = hs_cmd;
  end

  bms_sync #(.WIDTH(FLAG_COUNT)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(raw_flags),
    .sync_o (sflags)
  );

  bms_timers #(.DWELL_CYC(DWELL_CYC), .IDLE_CYC(IDLE_CYC)) u_timers (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_chg    (mode_chg),
    .ls_s        (sflags[FLAG_LS]),
    .dwell_done  (dwell_done),
    .idle_expired(idle_expired)
  );

  bms_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .f_above_on  (sflags[FLAG_ABOVE_ON]),
    .f_below_off (sflags[FLAG_BELOW_OFF]),
    .f_below_ref (sflags[FLAG_BELOW_REF]),
    .f_ref_good  (sflags[FLAG_REF_GOOD]),
    .f_ref_low   (sflags[FLAG_REF_LOW]),
    .hs_s        (sflags[FLAG_HS]),
    .dwell_done  (dwell_done),
    .idle_expired(idle_expired),
    .mode_q      (mode_q),
    .mode_chg    (mode_chg)
  );

  bms_outdec u_outdec (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_q      (mode_q),
    .f_above_on  (sflags[FLAG_ABOVE_ON]),
    .f_below_save(sflags[FLAG_BELOW_SAVE]),
    .outs        (outs)
  );

  assign mode       = mode_q;
  assign gen_on     = outs.gen_on;
  assign ref_en     = outs.ref_en;
  assign ref_hi_cur = outs.ref_hi_cur;
  assign ref_clamp  = outs.ref_clamp;
  assign reg_en     = outs.reg_en;
  assign ocp_en     = outs.ocp_en;
  assign drv_en     = outs.drv_en;

  a_r1_reset_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mode == 2'd0));
endmodule

// File: tb/test_ballast_mode_seq.sv
`timescale 1ns/1ps
module test_ballast_mode_seq;
  localparam int unsigned D = 8;
  localparam int unsigned I = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic above_on = 0, below_save = 0, below_off = 0, below_ref = 0;
  logic ref_good = 0, ref_low = 0, ls = 0, hs = 1;
  logic [1:0] mode;
  logic gen_on, ref_en, ref_hi_cur, ref_clamp, reg_en, ocp_en, drv_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  ballast_mode_seq #(.DWELL_CYC(D), .IDLE_CYC(I)) i_ballast_mode_seq (
    .clk(clk), .rst_n(rst_n),
    .vcc_above_on(above_on), .vcc_below_save(below_save),
    .vcc_below_off(below_off), .vcc_below_refoff(below_ref),
    .ref_good(ref_good), .ref_low(ref_low), .ls_cmd(ls), .hs_cmd(hs),
    .mode(mode), .gen_on(gen_on), .ref_en(ref_en), .ref_hi_cur(ref_hi_cur),
    .ref_clamp(ref_clamp), .reg_en(reg_en), .ocp_en(ocp_en), .drv_en(drv_en)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_mode(input string req, input int exp);
    chk(req, int'(mode), exp);
  endtask

  // expected enables {gen,ref_en,ref_hi,clamp,reg,ocp,drv}
  task automatic chk_outs(input string req, input int m, input bit gen_save);
    logic [6:0] e;
    logic [6:0] a;
    if (m == 0)      e = 7'b1001000;
    else if (m == 1) e = {gen_save, 6'b100000};
    else if (m == 2) e = 7'b0110111;
    else             e = 7'b1100000;
    a = {gen_on, ref_en, ref_hi_cur, ref_clamp, reg_en, ocp_en, drv_en};
    chk(req, int'(a), int'(e));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk_mode("R1 reset mode", 0);
    chk_outs("R1 R9 start enables", 0, 0);

    // R10: hs fall in start-up has no effect
    hs = 0; cyc(5);
    chk_mode("R10 hs fall in start-up", 0);

    // R2: start-up to save, three-edge latency
    above_on = 1; cyc(2);
    chk_mode("R2 before latency", 0);
    cyc(1);
    chk_mode("R2 enter save", 1);
    chk_outs("R9 R3 save enables gen off", 1, 0);

    // R3: generator hysteresis
    above_on = 0; cyc(4);
    chk_outs("R3 hold off", 1, 0);
    below_save = 1; cyc(2);
    chk_outs("R3 before turn-on", 1, 0);
    cyc(1);
    chk_outs("R3 gen on below save level", 1, 1);
    below_save = 0; cyc(4);
    chk_outs("R3 hold on", 1, 1);
    above_on = 1; cyc(3);
    chk_outs("R3 gen off above turn-on", 1, 0);

    // R10: turn-off flag ignored in save
    below_off = 1; cyc(5);
    chk_mode("R10 below_off in save", 1);
    below_off = 0; cyc(3);

    // R5: reference not good blocks operating
    hs = 1; cyc(3); hs = 0; cyc(4);
    chk_mode("R5 ref not good", 1);

    // R4: enter operating
    ref_good = 1; hs = 1; cyc(3); hs = 0; cyc(2);
    chk_mode("R4 before latency", 1);
    cyc(1);
    chk_mode("R4 enter operating", 2);
    chk_outs("R9 operating enables", 2, 0);

    // R6: low-side edges keep operating alive
    for (int k = 0; k < 6; k++) begin
      cyc(10); ls = ~ls;
      chk_mode("R6 activity keeps operating", 2);
    end
    cyc(23);
    chk_mode("R6 last idle cycle after edge", 2);
    cyc(1);
    chk_mode("R6 idle return to save", 1);

    // R4: edge seen one cycle short of dwell is ignored
    hs = 1; cyc(D - 3); hs = 0; cyc(3);
    chk_mode("R4 dwell short by one", 1);
    hs = 1; cyc(3); hs = 0; cyc(3);
    chk_mode("R4 re-enter operating", 2);

    // R6: no activity at all
    cyc(I);
    chk_mode("R6 operating at limit", 2);
    cyc(1);
    chk_mode("R6 save after limit", 1);

    // R4: edge seen exactly at dwell limit is accepted
    hs = 1; cyc(D - 2); hs = 0; cyc(2);
    chk_mode("R4 exact dwell pending", 1);
    cyc(1);
    chk_mode("R4 exact dwell accepted", 2);

    // R7: supply fault
    above_on = 0; below_off = 1; cyc(2);
    chk_mode("R7 before latency", 2);
    cyc(1);
    chk_mode("R7 supply fault to shut-down", 3);
    chk_outs("R9 shut-down enables", 3, 0);
    cyc(I + 5);
    chk_mode("R7 shut-down ignores idle", 3);

    // R8: shut-down to save
    below_off = 0; above_on = 1; cyc(3);
    chk_mode("R8 shut-down to save", 1);

    // R7: reference fault
    hs = 1; cyc(D); hs = 0; cyc(3);
    chk_mode("R7 setup operating", 2);
    above_on = 0; ref_low = 1; cyc(3);
    chk_mode("R7 reference fault", 3);
    ref_low = 0;

    // R8: reference-off beats turn-on
    above_on = 1; below_ref = 1; cyc(3);
    chk_mode("R8 priority to start-up", 0);
    chk_outs("R9 start enables again", 0, 0);
    below_ref = 0; cyc(3);
    chk_mode("R8 start-up to save", 1);
    above_on = 0; below_ref = 1; cyc(3);
    chk_mode("R8 save to start-up", 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule